// File: doc/BRIEF.md
# USB Endpoint Receive Status Tracker

This block keeps the per-endpoint receive bookkeeping of a full-speed USB peripheral. Four endpoints each own two buffer register sets (A and B), giving eight slots. For every slot, firmware programs a base length: the largest packet that the slot's buffer may take. A packet engine upstream reports each transaction to this block. It sends a token strobe naming the endpoint, the buffer set and the token kind. It then sends one strobe per received data byte, CRC and PID error flags, and an end-of-packet pulse. The pulse comes with the handshake outcome and the data PID parity.

On the end-of-packet pulse, the addressed slot captures a status byte and a leftover count. The leftover count is the base length minus the bytes received. The status byte holds acknowledge, error, data toggle, setup and overflow flags. All slot registers sit behind an 8-bit address-mapped register port. Reads are combinational. Writes are accepted only by the base-length registers.

Top module: `usbep_stat_top`

## Requirements
- R1: Address = endpoint*16 + set*8 + offset, where set A is 0 and set B is 1. The offsets are 2 for base length (read/write), 3 for status and 4 for count. Status and count ignore writes. Any other offset, and any address with bits 7:6 nonzero, reads 0.
- R2: Status bits: bit 0 acknowledge, bit 1 error, bit 2 time-out (always 0), bit 3 data toggle, bit 4 setup, bit 5 overflow. Bits 7:6 always read 0.
- R3: After an OUT packet (token kind 0) of N bytes with N no larger than the base length B, the count reads B-N. For example, B=64 and N=16 gives 48.
- R4: An OUT packet with N > B sets the overflow bit, forces the count to 0 and clears the acknowledge bit.
- R5: Overflow is only ever set by OUT tokens. A SETUP packet (kind 2) loads the count as B-N, saturated at 0, with overflow 0. An IN packet (kind 1, or the spare kind 3) leaves the count unchanged and overflow 0.
- R6: The data toggle bit takes the data PID parity present at end of packet: 0 for DATA0, 1 for DATA1.
- R7: The setup bit is 1 after a SETUP packet and 0 after any other kind.
- R8: The error bit is 1 if a CRC or PID error flag was high on any cycle from the token strobe through the end-of-packet cycle.
- R9: The acknowledge bit equals the handshake input at end of packet, unless the packet overflowed.
- R10: Status and count change only on the clock edge that samples end of packet, and only in the slot named by the last token. The new values are readable from the next cycle.
- R11: An active-low reset clears every base length, status and count to 0.
- R12: A byte strobe in the end-of-packet cycle is counted. The byte counter saturates above 255, so any packet longer than a base length of 255 still overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tok_valid | input | 1 | Token strobe, starts a packet |
| tok_ep | input | 2 | Endpoint number of the token |
| tok_set | input | 1 | Buffer set of the token (0 = A, 1 = B) |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 treated as IN |
| byte_stb | input | 1 | One pulse per received data byte |
| err_crc | input | 1 | CRC5/CRC16 error flag |
| err_pid | input | 1 | PID error flag |
| eop | input | 1 | End-of-packet pulse |
| hs_ack | input | 1 | Handshake was acknowledge (valid with eop) |
| data1 | input | 1 | Data PID is DATA1 (valid with eop) |

## Verification
The count and overflow path is tried with byte totals below, equal to and above the base length. This separates the exact-fit case from the first byte of overflow. It also includes bases of 0 and 255 and packets longer than 256 bytes, which would expose a counter that wraps instead of saturating. The token kind is varied over OUT, SETUP and IN. This shows that overflow and count loading depend on the kind, and that the setup bit is cleared again. Error flags placed on the token, a middle byte or the end cycle show that errors are kept until end of packet. After every packet all eight slots are read back, so a commit into the wrong endpoint or buffer set shows up as a changed neighbour.

// File: rtl/usbep_pkg.sv
package usbep_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_SPARE = 2'd3
  } tok_kind_e;

  localparam logic [2:0] OFS_BASE = 3'd2;
  localparam logic [2:0] OFS_STAT = 3'd3;
  localparam logic [2:0] OFS_CNT  = 3'd4;

  typedef struct packed {
    logic [1:0] zero_hi;
    logic       ovf;
    logic       setup;
    logic       seq;
    logic       tmo;
    logic       err;
    logic       ack;
  } stat_t;
endpackage

// File: rtl/usbep_pkt_acc.sv
module usbep_pkt_acc
  import usbep_pkg::*;
#(
  parameter int EP_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tok_valid,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            tok_set,
  input  tok_kind_e       tok_kind,
  input  logic            byte_stb,
  input  logic            err_crc,
  input  logic            err_pid,
  output logic [EP_W-1:0] cur_ep,
  output logic            cur_set,
  output tok_kind_e       cur_kind,
  output logic [DW:0]     bytes_tot,
  output logic            err_tot
);
  localparam logic [DW:0] CNT_MAX = '1;

  logic [EP_W-1:0] ep_q, ep_d;
  logic            set_q, set_d;
  tok_kind_e       kind_q, kind_d;
  logic [DW:0]     cnt_q, cnt_d;
  logic            err_q, err_d;
  logic            bump;

  assign bump      = byte_stb && (cnt_q != CNT_MAX);
  assign bytes_tot = bump ? cnt_q + 1'b1 : cnt_q;
  assign err_tot   = err_q | err_crc | err_pid;

  always_comb begin
    ep_d   = ep_q;
    set_d  = set_q;
    kind_d = kind_q;
    cnt_d  = bytes_tot;
    err_d  = err_tot;
    if (tok_valid) begin
      ep_d   = tok_ep;
      set_d  = tok_set;
      kind_d = tok_kind;
      cnt_d  = '0;
      err_d  = err_crc | err_pid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_q   <= '0;
      set_q  <= 1'b0;
      kind_q <= TOK_IN;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      ep_q   <= ep_d;
      set_q  <= set_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
    end
  end

  assign cur_ep   = ep_q;
  assign cur_set  = set_q;
  assign cur_kind = kind_q;
endmodule

// File: rtl/usbep_slot.sv
module usbep_slot
  import usbep_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [DW-1:0] base_wdata,
  input  logic          commit,
  input  tok_kind_e     kind,
  input  logic [DW:0]   bytes_tot,
  input  logic          err_tot,
  input  logic          data1,
  input  logic          hs_ack,
  output logic [DW-1:0] base_q,
  output stat_t         stat_q,
  output logic [DW-1:0] cnt_q
);
  logic [DW-1:0] base_d, cnt_d, rem;
  stat_t         stat_d;
  logic          over, fits, loads_cnt;

  assign fits      = bytes_tot <= {1'b0, base_q};
  assign over      = (kind == TOK_OUT) && !fits;
  assign rem       = fits ? base_q - bytes_tot[DW-1:0] : '0;
  assign loads_cnt = (kind == TOK_OUT) || (kind == TOK_SETUP);

  always_comb begin
    base_d = base_we ? base_wdata : base_q;
    stat_d = stat_q;
    cnt_d  = cnt_q;
    if (commit) begin
      stat_d.zero_hi = 2'b00;
      stat_d.ovf     = over;
      stat_d.setup   = (kind == TOK_SETUP);
      stat_d.seq     = data1;
      stat_d.tmo     = 1'b0;
      stat_d.err     = err_tot;
      stat_d.ack     = hs_ack && !over;
      if (loads_cnt) cnt_d = rem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      stat_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      stat_q <= stat_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/usbep_regmux.sv
module usbep_regmux
  import usbep_pkg::*;
#(
  parameter int EP_W   = 2,
  parameter int N_SLOT = 8
) (
  input  logic [7:0]                  reg_addr,
  input  logic                        reg_wr,
  input  logic [N_SLOT-1:0][DW-1:0]   base_arr,
  input  logic [N_SLOT-1:0][DW-1:0]   stat_arr,
  input  logic [N_SLOT-1:0][DW-1:0]   cnt_arr,
  output logic [DW-1:0]               reg_rdata,
  output logic [N_SLOT-1:0]           base_we
);
  localparam int SLOT_W = EP_W + 1;

  logic              in_map;
  logic [SLOT_W-1:0] idx;
  logic [2:0]        ofs;

  assign in_map = (reg_addr >> (EP_W + 4)) == 8'd0;
  assign idx    = {reg_addr[EP_W+3:4], reg_addr[3]};
  assign ofs    = reg_addr[2:0];

  always_comb begin
    reg_rdata = '0;
    base_we   = '0;
    if (in_map) begin
      case (ofs)
        OFS_BASE: begin
          reg_rdata    = base_arr[idx];
          base_we[idx] = reg_wr;
        end
        OFS_STAT: reg_rdata = stat_arr[idx];
        OFS_CNT:  reg_rdata = cnt_arr[idx];
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/usbep_stat_top.sv
module usbep_stat_top
  import usbep_pkg::*;
#(
  parameter int N_EP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               reg_addr,
  input  logic                     reg_wr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  input  logic                     tok_valid,
  input  logic [$clog2(N_EP)-1:0]  tok_ep,
  input  logic                     tok_set,
  input  logic [1:0]               tok_kind,
  input  logic                     byte_stb,
  input  logic                     err_crc,
  input  logic                     err_pid,
  input  logic                     eop,
  input  logic                     hs_ack,
  input  logic                     data1
);
  localparam int EP_W   = $clog2(N_EP);
  localparam int N_SLOT = 2 * N_EP;

  logic [EP_W-1:0]            cur_ep;
  logic                       cur_set;
  tok_kind_e                  cur_kind;
  logic [DW:0]                bytes_tot;
  logic                       err_tot;
  logic [N_SLOT-1:0]          base_we;
  logic [N_SLOT-1:0][DW-1:0]  base_arr;
  logic [N_SLOT-1:0][DW-1:0]  stat_arr;
  logic [N_SLOT-1:0][DW-1:0]  cnt_arr;

  usbep_pkt_acc #(.EP_W(EP_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .tok_ep    (tok_ep),
    .tok_set   (tok_set),
    .tok_kind  (tok_kind_e'(tok_kind)),
    .byte_stb  (byte_stb),
    .err_crc   (err_crc),
    .err_pid   (err_pid),
    .cur_ep    (cur_ep),
    .cur_set   (cur_set),
    .cur_kind  (cur_kind),
    .bytes_tot (bytes_tot),
    .err_tot   (err_tot)
  );

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    stat_t slot_stat;
    logic  hit;
    assign hit = eop && (cur_ep == EP_W'(s / 2)) && (cur_set == s[0]);

    usbep_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_we    (base_we[s]),
      .base_wdata (reg_wdata),
      .commit     (hit),
      .kind       (cur_kind),
      .bytes_tot  (bytes_tot),
      .err_tot    (err_tot),
      .data1      (data1),
      .hs_ack     (hs_ack),
      .base_q     (base_arr[s]),
      .stat_q     (slot_stat),
      .cnt_q      (cnt_arr[s])
    );
    assign stat_arr[s] = slot_stat;
  end

  usbep_regmux #(.EP_W(EP_W), .N_SLOT(N_SLOT)) u_mux (
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .base_arr  (base_arr),
    .stat_arr  (stat_arr),
    .cnt_arr   (cnt_arr),
    .reg_rdata (reg_rdata),
    .base_we   (base_we)
  );
endmodule

// File: rtl/usbep_stat_chk.sv
module usbep_stat_chk
  import usbep_pkg::*;
#(
  parameter int N_SLOT = 8,
  parameter int EP_W   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [7:0]                reg_addr,
  input logic [7:0]                reg_rdata,
  input logic                      eop,
  input tok_kind_e                 cur_kind,
  input logic [N_SLOT-1:0][DW-1:0] stat_arr,
  input logic [N_SLOT-1:0][DW-1:0] cnt_arr
);
  // Addresses above the endpoint field read as zero (R1)
  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr >> (EP_W + 4)) != 8'd0) |-> (reg_rdata == 8'd0));

  for (genvar g = 0; g < N_SLOT; g++) begin : g_chk
    assert_stat_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_arr[g][7:6] == 2'b00) && !stat_arr[g][2]);

    assert_overflow_kills_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stat_arr[g][5] |-> (!stat_arr[g][0] && (cnt_arr[g] == 8'd0)));

    assert_overflow_from_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_arr[g][5]) |-> ($past(cur_kind) == TOK_OUT));

    assert_setup_never_overflows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_arr[g][4] |-> !stat_arr[g][5]);

    assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !eop |=> ($stable(stat_arr[g]) && $stable(cnt_arr[g])));
  end
endmodule

bind usbep_stat_top usbep_stat_chk #(.N_SLOT(N_SLOT), .EP_W(EP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .eop       (eop),
  .cur_kind  (cur_kind),
  .stat_arr  (stat_arr),
  .cnt_arr   (cnt_arr)
);

// File: tb/usbep_stat_top_tb_top.sv
module usbep_stat_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_ep = '0;
  logic       tok_set = 1'b0;
  logic [1:0] tok_kind = '0;
  logic       byte_stb = 1'b0;
  logic       err_crc = 1'b0;
  logic       err_pid = 1'b0;
  logic       eop = 1'b0;
  logic       hs_ack = 1'b0;
  logic       data1 = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] m_base [8];
  logic [7:0] m_stat [8];
  logic [7:0] m_cnt  [8];

  always #2.5 clk = ~clk;

  usbep_stat_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_valid(tok_valid),
    .tok_ep(tok_ep), .tok_set(tok_set), .tok_kind(tok_kind), .byte_stb(byte_stb),
    .err_crc(err_crc), .err_pid(err_pid), .eop(eop), .hs_ack(hs_ack), .data1(data1)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_of(int s, int ofs);
    return 8'((s / 2) * 16 + (s % 2) * 8 + ofs);
  endfunction

  function automatic logic [7:0] exp_stat(int kind, int nb, logic [7:0] base,
                                          bit d1, bit err, bit ack);
    bit over = (kind == 0) && (nb > int'(base));
    return {2'b00, over, kind == 2, d1, 1'b0, err, ack && !over};
  endfunction

  function automatic logic [7:0] exp_left(int nb, logic [7:0] base);
    return (nb <= int'(base)) ? 8'(int'(base) - nb) : 8'd0;
  endfunction

  task automatic reg_read(logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic reg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_base(int s, logic [7:0] b);
    reg_write(addr_of(s, 2), b);
    m_base[s] = b;
  endtask

  // err_at: -1 none, 0 on token cycle, k>0 on byte k, >= byte count on eop cycle
  task automatic send_pkt(int s, int kind, int nb, bit d1, int err_at,
                          bit pid_err, bit ack, bit last_on_eop);
    int pre = (last_on_eop && nb > 0) ? nb - 1 : nb;
    bit err_seen = (err_at >= 0);
    @(negedge clk);
    tok_valid = 1'b1; tok_ep = 2'(s / 2); tok_set = s[0]; tok_kind = 2'(kind);
    if (err_at == 0) begin err_crc = !pid_err; err_pid = pid_err; end
    @(negedge clk);
    tok_valid = 1'b0; err_crc = 1'b0; err_pid = 1'b0;
    for (int i = 1; i <= pre; i++) begin
      byte_stb = 1'b1;
      if (err_at == i && err_at < pre) begin err_crc = !pid_err; err_pid = pid_err; end
      @(negedge clk);
      byte_stb = 1'b0; err_crc = 1'b0; err_pid = 1'b0;
    end
    eop = 1'b1; hs_ack = ack; data1 = d1;
    byte_stb = (last_on_eop && nb > 0);
    if (err_at > 0 && err_at >= pre) begin err_crc = !pid_err; err_pid = pid_err; end
    @(negedge clk);
    eop = 1'b0; hs_ack = 1'b0; data1 = 1'b0; byte_stb = 1'b0;
    err_crc = 1'b0; err_pid = 1'b0;
    m_stat[s] = exp_stat(kind, nb, m_base[s], d1, err_seen, ack);
    if (kind == 0 || kind == 2) m_cnt[s] = exp_left(nb, m_base[s]);
  endtask

  task automatic check_all(int tgt, string tag_stat, string tag_cnt);
    logic [7:0] v;
    for (int s = 0; s < 8; s++) begin
      reg_read(addr_of(s, 3), v);
      chk((s == tgt) ? tag_stat : "R10 neighbour status", v, m_stat[s]);
      reg_read(addr_of(s, 4), v);
      chk((s == tgt) ? tag_cnt : "R10 neighbour count", v, m_cnt[s]);
      reg_read(addr_of(s, 2), v);
      chk("R1 base readback", v, m_base[s]);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 8; s++) begin
      m_base[s] = '0; m_stat[s] = '0; m_cnt[s] = '0;
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all(-1, "R11", "R11");

    // R3: exact example
    set_base(0, 8'd64);
    send_pkt(0, 0, 16, 1'b0, -1, 1'b0, 1'b1, 1'b0);
    check_all(0, "R9 status after OUT", "R3 leftover 64-16");
    reg_read(addr_of(0, 4), v); chk("R3 value 48", v, 8'd48);

    // R3 exact fit, R6 DATA1
    set_base(3, 8'd8);
    send_pkt(3, 0, 8, 1'b1, -1, 1'b0, 1'b1, 1'b0);
    check_all(3, "R6 toggle DATA1", "R3 exact fit");

    // R4 overflow by one
    set_base(5, 8'd10);
    send_pkt(5, 0, 11, 1'b0, -1, 1'b0, 1'b1, 1'b0);
    check_all(5, "R4 overflow status", "R4 overflow count");
    reg_read(addr_of(5, 3), v); chk("R2 R4 overflow bit5 ack bit0", v, 8'h20);

    // R12 base 255 with 260 bytes, byte on eop
    set_base(6, 8'd255);
    send_pkt(6, 0, 260, 1'b1, -1, 1'b0, 1'b1, 1'b1);
    check_all(6, "R12 saturating overflow", "R12 count");
    send_pkt(6, 0, 255, 1'b0, -1, 1'b0, 1'b1, 1'b1);
    check_all(6, "R12 eop byte fit status", "R12 eop byte counted");

    // R7 SETUP sets, R5 SETUP over base saturates without overflow
    set_base(1, 8'd8);
    send_pkt(1, 2, 12, 1'b0, -1, 1'b0, 1'b1, 1'b0);
    check_all(1, "R7 R5 setup no overflow", "R5 setup count saturated");
    send_pkt(1, 0, 3, 1'b1, -1, 1'b0, 1'b1, 1'b0);
    check_all(1, "R7 setup cleared", "R3 after setup");
    // R5 IN leaves count
    send_pkt(1, 1, 0, 1'b0, -1, 1'b0, 1'b1, 1'b0);
    check_all(1, "R5 IN status", "R5 IN count unchanged");
    send_pkt(1, 3, 0, 1'b1, -1, 1'b0, 1'b0, 1'b0);
    check_all(1, "R5 spare kind status", "R5 spare kind count");

    // R8 errors on token, middle byte, eop; R9 nak
    set_base(7, 8'd32);
    send_pkt(7, 0, 5, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    check_all(7, "R8 crc on token R9 nak", "R3 count");
    send_pkt(7, 0, 5, 1'b0, 2, 1'b1, 1'b1, 1'b0);
    check_all(7, "R8 pid mid packet", "R3 count");
    send_pkt(7, 0, 5, 1'b1, 9, 1'b0, 1'b1, 1'b0);
    check_all(7, "R8 crc on eop", "R3 count");
    send_pkt(7, 0, 5, 1'b1, -1, 1'b0, 1'b1, 1'b0);
    check_all(7, "R8 error cleared", "R3 count");

    // R1 writes to status/count ignored, unmapped reads zero
    reg_write(addr_of(7, 3), 8'hFF);
    reg_write(addr_of(7, 4), 8'hFF);
    reg_write(8'h45, 8'h77);
    check_all(-1, "R1", "R1");
    reg_read(8'h40 + addr_of(0, 2), v); chk("R1 high address reads 0", v, 8'h00);
    reg_read(8'h05, v); chk("R1 unused offset reads 0", v, 8'h00);
    // base 0 with zero-length OUT
    set_base(2, 8'd0);
    send_pkt(2, 0, 0, 1'b1, -1, 1'b0, 1'b1, 1'b0);
    check_all(2, "R2 zero base fit", "R3 zero base");

    // constrained random
    for (int k = 0; k < 60; k++) begin
      int s = $urandom_range(7);
      int kind = $urandom_range(3);
      int nb;
      if ($urandom_range(3) == 0) set_base(s, 8'($urandom_range(255)));
      nb = int'(m_base[s]) + $urandom_range(6) - 3;
      if (nb < 0) nb = 0;
      if ($urandom_range(4) == 0) nb = $urandom_range(40);
      send_pkt(s, kind, nb, 1'($urandom_range(1)),
               ($urandom_range(2) == 0) ? $urandom_range(nb + 1) : -1,
               1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)));
      check_all(s, "R2 R6 R7 R8 R9 random status", "R3 R4 R5 random count");
    end

    // R11 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    check_all(-1, "R11 status after reset", "R11 count after reset");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule